// File: doc/BRIEF.md
# Interrupt Source State Controller

This block is the source half of a two-level interrupt controller. It holds the state of a parameterised set of interrupt sources, numbered upward from a base offset. A strap input sets each source to be either level-sensitive or message-style. For every source the block keeps a destination server, a current priority, a saved priority and four status flags: asserted, sent, rejected and masked-pending. When a source becomes deliverable, the block issues a presentation request made of the source number, the server and the priority. A presentation layer outside this block consumes that request. The same layer can later send back a reject, an end-of-interrupt (EOI) or a resend request.

Presentation requests leave on a valid/ready stream. A payload stays stable while `pres_valid` is high and `pres_ready` is low. When several sources are waiting, the lowest-numbered one goes first. The configuration port is also valid/ready. It accepts set, get, disable and enable operations. `cfg_ready` goes low only while a resend scan is running. Each accepted operation gives a one-cycle response on the following cycle, and that response has no back-pressure.

A resend walks through the sources in ascending order, one per cycle. The walk pauses whenever a presentation is held by back-pressure. Priority 0xFF means the source is masked.

Top module: `irq_source_ctrl`

## Requirements
- R1: After reset no presentation is pending. `cfg_ready` is 1. Every source reads back server 0 and priority 0xFF, and its status flags are clear.
- R2: A source number is valid when BASE <= num < BASE+NUM_SRC. An operation is rejected with response code 0xFD (-3) if its number is out of range, or if it is a set whose server is >= NUM_SRV. A rejected operation changes no state. A successful operation returns code 0x00.
- R3: A set (op 0) stores the server, and it stores the priority as both the current and the saved priority. A get (op 1) returns the server and the current priority. `rsp_valid` pulses on the cycle after acceptance.
- R4: A rising input on an unmasked message source requests presentation of {BASE+i, server, priority}.
- R5: A rising input on a masked message source sets masked-pending and presents nothing. A later write that unmasks the source clears the flag and presents the source.
- R6: A level source stores its input as the asserted flag. It presents when it is unmasked, asserted, not sent and not rejected, and presenting sets sent. An EOI clears sent, so a source that is still asserted presents again. An EOI to a message source has no effect.
- R7: A reject sets rejected and clears sent. A rejected source does not present again until a resend. A level source also comes back after a change of its input or a configuration write.
- R8: A resend visits one source per cycle in ascending order. At each visit, a rejected message source clears its rejected flag and is queued if unmasked. The scan pauses while a presentation is held, and `cfg_ready` is 0 until the scan ends.
- R9: A disable (op 2) saves the current priority and writes 0xFF. An enable (op 3) restores the priority from the saved priority.
- R10: While `pres_valid` is high and `pres_ready` is low, the payload holds. Among the sources waiting, the lowest index is presented first.
- R11: Masking a message source that is queued but not yet presented moves that request to masked-pending. A later enable presents it.
- R12: Reject and EOI requests that carry an out-of-range number are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_in | input | NUM_SRC | Per-source interrupt input; the source takes the level or the rising edge depending on its mode |
| src_mode | input | NUM_SRC | Static mode strap: 1 = level source, 0 = message source |
| rej_valid | input | 1 | Reject request from the presentation layer |
| rej_num | input | NUM_W | Source number to reject |
| eoi_valid | input | 1 | End-of-interrupt request |
| eoi_num | input | NUM_W | Source number of the EOI |
| resend_req | input | 1 | Start a resend scan |
| pres_valid | output | 1 | A presentation request is offered |
| pres_ready | input | 1 | The presentation layer accepts the request |
| pres_num | output | NUM_W | Presented source number |
| pres_server | output | SRV_W | Presented destination server |
| pres_prio | output | 8 | Presented priority |
| cfg_valid | input | 1 | Configuration operation offered |
| cfg_ready | output | 1 | Operation can be accepted (low during a scan) |
| cfg_op | input | 2 | 0 set, 1 get, 2 disable, 3 enable |
| cfg_num | input | NUM_W | Source number of the operation |
| cfg_server | input | SRV_W | Server for a set |
| cfg_prio | input | 8 | Priority for a set |
| rsp_valid | output | 1 | Response pulse, one cycle after acceptance |
| rsp_code | output | 8 | 0x00 success, 0xFD argument error |
| rsp_server | output | SRV_W | Server returned by a get, otherwise 0 |
| rsp_prio | output | 8 | Priority returned by a get, otherwise 0 |

## Verification
Message sources are driven with single pulses, both masked and unmasked, and with two pulses in the same cycle. These patterns separate immediate presentation, parking in masked-pending, and lowest-index ordering under a held request. Level sources are held high across EOIs, rejects and resends, which shows whether the sent and rejected flags gate re-presentation correctly. A resend is issued while the stream is stalled, which reveals the per-cycle scan order, the pause and the configuration lock-out. Operations with out-of-range numbers and servers, and rejects and EOIs with out-of-range numbers, confirm that bad arguments leave the state untouched.

// File: rtl/isc_pkg.sv
package isc_pkg;
  typedef enum logic [1:0] {
    OP_SET = 2'd0,
    OP_GET = 2'd1,
    OP_OFF = 2'd2,
    OP_ON  = 2'd3
  } cfg_op_e;

  localparam logic [7:0] PRIO_MASKED = 8'hFF;
  localparam logic [7:0] RSP_OK      = 8'h00;
  localparam logic [7:0] RSP_BADARG  = 8'hFD;
endpackage

// File: rtl/isc_src_cell.sv
module isc_src_cell
  import isc_pkg::*;
#(
  parameter int SRV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sig_in,
  input  logic             lvl_mode,
  input  logic             wr_en,
  input  logic [SRV_W-1:0] wr_server,
  input  logic [7:0]       wr_prio,
  input  logic [7:0]       wr_saved,
  input  logic             rej_hit,
  input  logic             eoi_hit,
  input  logic             scan_hit,
  input  logic             grant,
  output logic [SRV_W-1:0] server,
  output logic [7:0]       prio,
  output logic [7:0]       saved,
  output logic             req
);
  logic in_q, asserted, sent, rejected, mpend, pend;
  logic pend_n, mpend_n;

  logic [7:0] prio_nx;
  logic       masked, masked_nx, msg_evt, lvl_chg;

  assign masked    = (prio == PRIO_MASKED);
  assign prio_nx   = wr_en ? wr_prio : prio;
  assign masked_nx = (prio_nx == PRIO_MASKED);
  assign msg_evt   = !lvl_mode && sig_in && !in_q;
  assign lvl_chg   = lvl_mode && (sig_in != in_q);

  // Message-source queue and masked-pending update
  always_comb begin
    pend_n  = pend && !grant;
    mpend_n = mpend;
    if (msg_evt) begin
      if (masked) mpend_n = 1'b1;
      else        pend_n  = 1'b1;
    end
    if (scan_hit && rejected && !rej_hit && !masked) pend_n = 1'b1;
    if (wr_en) begin
      if (masked_nx) begin
        if (pend_n) begin
          mpend_n = 1'b1;
          pend_n  = 1'b0;
        end
      end else if (mpend_n) begin
        mpend_n = 1'b0;
        pend_n  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_q     <= 1'b0;
      asserted <= 1'b0;
      sent     <= 1'b0;
      rejected <= 1'b0;
      mpend    <= 1'b0;
      pend     <= 1'b0;
      server   <= '0;
      prio     <= PRIO_MASKED;
      saved    <= PRIO_MASKED;
    end else begin
      in_q <= sig_in;
      if (wr_en) begin
        server <= wr_server;
        prio   <= wr_prio;
        saved  <= wr_saved;
      end
      if (lvl_mode) begin
        asserted <= sig_in;
        pend     <= 1'b0;
        mpend    <= 1'b0;
        if (rej_hit) begin
          rejected <= 1'b1;
          sent     <= 1'b0;
        end else begin
          if (scan_hit || lvl_chg || wr_en) rejected <= 1'b0;
          if (grant)        sent <= 1'b1;
          else if (eoi_hit) sent <= 1'b0;
        end
      end else begin
        asserted <= 1'b0;
        sent     <= 1'b0;
        if (rej_hit)       rejected <= 1'b1;
        else if (scan_hit) rejected <= 1'b0;
        pend  <= pend_n;
        mpend <= mpend_n;
      end
    end
  end

  assign req = lvl_mode ? (!masked && asserted && !sent && !rejected) : pend;
endmodule

// File: rtl/isc_present_arb.sv
module isc_present_arb #(
  parameter int NUM_SRC = 8,
  parameter int BASE    = 16,
  parameter int NUM_W   = 10,
  parameter int SRV_W   = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_SRC-1:0]             req,
  input  logic [NUM_SRC-1:0][SRV_W-1:0]  srv_a,
  input  logic [NUM_SRC-1:0][7:0]        prio_a,
  input  logic                           pres_ready,
  output logic [NUM_SRC-1:0]             grant,
  output logic                           pres_valid,
  output logic [NUM_W-1:0]               pres_num,
  output logic [SRV_W-1:0]               pres_server,
  output logic [7:0]                     pres_prio
);
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic             found, load;
  logic [IDX_W-1:0] sel;

  always_comb begin
    found = 1'b0;
    sel   = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (req[i] && !found) begin
        found = 1'b1;
        sel   = IDX_W'(i);
      end
    end
  end

  assign load = found && (!pres_valid || pres_ready);

  always_comb begin
    grant = '0;
    if (load) grant[sel] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pres_valid  <= 1'b0;
      pres_num    <= '0;
      pres_server <= '0;
      pres_prio   <= '0;
    end else if (load) begin
      pres_valid  <= 1'b1;
      pres_num    <= NUM_W'(BASE) + NUM_W'(sel);
      pres_server <= srv_a[sel];
      pres_prio   <= prio_a[sel];
    end else if (pres_ready) begin
      pres_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/isc_resend_scan.sv
module isc_resend_scan #(
  parameter int NUM_SRC = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               stall,
  output logic               busy,
  output logic [NUM_SRC-1:0] hit
);
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_SRC - 1);

  logic [IDX_W-1:0] idx;
  logic             again;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      idx   <= '0;
      again <= 1'b0;
    end else if (!busy) begin
      if (start) begin
        busy <= 1'b1;
        idx  <= '0;
      end
    end else if (!stall) begin
      if (idx == LAST) begin
        busy  <= again || start;
        again <= 1'b0;
        idx   <= '0;
      end else begin
        idx <= idx + 1'b1;
        if (start) again <= 1'b1;
      end
    end else if (start) begin
      again <= 1'b1;
    end
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_hit
    assign hit[i] = busy && !stall && (idx == IDX_W'(i));
  end
endmodule

// File: rtl/isc_cfg_port.sv
module isc_cfg_port
  import isc_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int NUM_SRV = 4,
  parameter int SRV_W   = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_valid,
  input  logic [1:0]                    cfg_op,
  input  logic [NUM_SRC-1:0]            sel,
  input  logic [SRV_W-1:0]              cfg_server,
  input  logic [7:0]                    cfg_prio,
  input  logic [NUM_SRC-1:0][SRV_W-1:0] srv_a,
  input  logic [NUM_SRC-1:0][7:0]       prio_a,
  input  logic [NUM_SRC-1:0][7:0]       saved_a,
  input  logic                          scan_busy,
  output logic                          cfg_ready,
  output logic                          wr_en,
  output logic [SRV_W-1:0]              wr_server,
  output logic [7:0]                    wr_prio,
  output logic [7:0]                    wr_saved,
  output logic                          rsp_valid,
  output logic [7:0]                    rsp_code,
  output logic [SRV_W-1:0]              rsp_server,
  output logic [7:0]                    rsp_prio
);
  cfg_op_e          op;
  logic             accept, hit, srv_ok, ok;
  logic [SRV_W-1:0] cur_srv;
  logic [7:0]       cur_prio, cur_saved;

  assign op        = cfg_op_e'(cfg_op);
  assign cfg_ready = !scan_busy;
  assign accept    = cfg_valid && cfg_ready;
  assign hit       = |sel;
  assign srv_ok    = {1'b0, cfg_server} < (SRV_W+1)'(NUM_SRV);
  assign ok        = hit && ((op != OP_SET) || srv_ok);
  assign wr_en     = accept && ok && (op != OP_GET);

  always_comb begin
    cur_srv   = '0;
    cur_prio  = '0;
    cur_saved = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (sel[i]) begin
        cur_srv   = cur_srv   | srv_a[i];
        cur_prio  = cur_prio  | prio_a[i];
        cur_saved = cur_saved | saved_a[i];
      end
    end
  end

  always_comb begin
    wr_server = cur_srv;
    wr_prio   = cur_prio;
    wr_saved  = cur_saved;
    case (op)
      OP_SET: begin
        wr_server = cfg_server;
        wr_prio   = cfg_prio;
        wr_saved  = cfg_prio;
      end
      OP_OFF: begin
        wr_prio  = PRIO_MASKED;
        wr_saved = cur_prio;
      end
      OP_ON: begin
        wr_prio  = cur_saved;
        wr_saved = cur_saved;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_code   <= RSP_OK;
      rsp_server <= '0;
      rsp_prio   <= '0;
    end else begin
      rsp_valid  <= accept;
      rsp_code   <= ok ? RSP_OK : RSP_BADARG;
      rsp_server <= (accept && ok && op == OP_GET) ? cur_srv  : '0;
      rsp_prio   <= (accept && ok && op == OP_GET) ? cur_prio : '0;
    end
  end
endmodule

// File: rtl/irq_source_ctrl.sv
module irq_source_ctrl #(
  parameter int NUM_SRC = 8,
  parameter int BASE    = 16,
  parameter int NUM_SRV = 4,
  parameter int NUM_W   = 10,
  parameter int SRV_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_in,
  input  logic [NUM_SRC-1:0] src_mode,
  input  logic               rej_valid,
  input  logic [NUM_W-1:0]   rej_num,
  input  logic               eoi_valid,
  input  logic [NUM_W-1:0]   eoi_num,
  input  logic               resend_req,
  output logic               pres_valid,
  input  logic               pres_ready,
  output logic [NUM_W-1:0]   pres_num,
  output logic [SRV_W-1:0]   pres_server,
  output logic [7:0]         pres_prio,
  input  logic               cfg_valid,
  output logic               cfg_ready,
  input  logic [1:0]         cfg_op,
  input  logic [NUM_W-1:0]   cfg_num,
  input  logic [SRV_W-1:0]   cfg_server,
  input  logic [7:0]         cfg_prio,
  output logic               rsp_valid,
  output logic [7:0]         rsp_code,
  output logic [SRV_W-1:0]   rsp_server,
  output logic [7:0]         rsp_prio
);
  logic [NUM_SRC-1:0]             rej_hit, eoi_hit, cfg_sel, scan_hit, grant, req;
  logic [NUM_SRC-1:0][SRV_W-1:0]  srv_a;
  logic [NUM_SRC-1:0][7:0]        prio_a, saved_a;
  logic                           wr_en, scan_busy, stall;
  logic [SRV_W-1:0]               wr_server;
  logic [7:0]                     wr_prio, wr_saved;

  assign stall = pres_valid && !pres_ready;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    localparam logic [NUM_W-1:0] SRC_NUM = NUM_W'(BASE + i);

    assign rej_hit[i] = rej_valid && (rej_num == SRC_NUM);
    assign eoi_hit[i] = eoi_valid && (eoi_num == SRC_NUM);
    assign cfg_sel[i] = (cfg_num == SRC_NUM);

    isc_src_cell #(.SRV_W(SRV_W)) u_cell (
      .clk       (clk),
      .rst_n     (rst_n),
      .sig_in    (src_in[i]),
      .lvl_mode  (src_mode[i]),
      .wr_en     (wr_en && cfg_sel[i]),
      .wr_server (wr_server),
      .wr_prio   (wr_prio),
      .wr_saved  (wr_saved),
      .rej_hit   (rej_hit[i]),
      .eoi_hit   (eoi_hit[i]),
      .scan_hit  (scan_hit[i]),
      .grant     (grant[i]),
      .server    (srv_a[i]),
      .prio      (prio_a[i]),
      .saved     (saved_a[i]),
      .req       (req[i])
    );
  end

  isc_resend_scan #(.NUM_SRC(NUM_SRC)) u_scan (
    .clk   (clk),
    .rst_n (rst_n),
    .start (resend_req),
    .stall (stall),
    .busy  (scan_busy),
    .hit   (scan_hit)
  );

  isc_present_arb #(
    .NUM_SRC(NUM_SRC), .BASE(BASE), .NUM_W(NUM_W), .SRV_W(SRV_W)
  ) u_arb (
    .clk         (clk),
    .rst_n       (rst_n),
    .req         (req),
    .srv_a       (srv_a),
    .prio_a      (prio_a),
    .pres_ready  (pres_ready),
    .grant       (grant),
    .pres_valid  (pres_valid),
    .pres_num    (pres_num),
    .pres_server (pres_server),
    .pres_prio   (pres_prio)
  );

  isc_cfg_port #(
    .NUM_SRC(NUM_SRC), .NUM_SRV(NUM_SRV), .SRV_W(SRV_W)
  ) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_valid  (cfg_valid),
    .cfg_op     (cfg_op),
    .sel        (cfg_sel),
    .cfg_server (cfg_server),
    .cfg_prio   (cfg_prio),
    .srv_a      (srv_a),
    .prio_a     (prio_a),
    .saved_a    (saved_a),
    .scan_busy  (scan_busy),
    .cfg_ready  (cfg_ready),
    .wr_en      (wr_en),
    .wr_server  (wr_server),
    .wr_prio    (wr_prio),
    .wr_saved   (wr_saved),
    .rsp_valid  (rsp_valid),
    .rsp_code   (rsp_code),
    .rsp_server (rsp_server),
    .rsp_prio   (rsp_prio)
  );
endmodule

// File: rtl/isc_checker.sv
module isc_checker #(
  parameter int NUM_SRC = 8,
  parameter int BASE    = 16,
  parameter int NUM_SRV = 4,
  parameter int NUM_W   = 10,
  parameter int SRV_W   = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pres_valid,
  input logic             pres_ready,
  input logic [NUM_W-1:0] pres_num,
  input logic [SRV_W-1:0] pres_server,
  input logic [7:0]       pres_prio,
  input logic             cfg_valid,
  input logic             cfg_ready,
  input logic             rsp_valid,
  input logic [7:0]       rsp_code,
  input logic             resend_req
);
  // R10
  pres_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pres_valid && !pres_ready |=> pres_valid && $stable(pres_num)
      && $stable(pres_server) && $stable(pres_prio));

  // R4
  pres_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pres_valid |-> (int'(pres_num) >= BASE) && (int'(pres_num) < BASE + NUM_SRC)
      && (pres_prio != 8'hFF) && (int'(pres_server) < NUM_SRV));

  // R3
  rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid && cfg_ready |=> rsp_valid);

  // R3
  rsp_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(cfg_valid && cfg_ready));

  // R2
  rsp_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_code == 8'h00 || rsp_code == 8'hFD));

  // R8
  scan_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resend_req && cfg_ready |=> !cfg_ready);
endmodule

bind irq_source_ctrl isc_checker #(
  .NUM_SRC(NUM_SRC), .BASE(BASE), .NUM_SRV(NUM_SRV), .NUM_W(NUM_W), .SRV_W(SRV_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pres_valid  (pres_valid),
  .pres_ready  (pres_ready),
  .pres_num    (pres_num),
  .pres_server (pres_server),
  .pres_prio   (pres_prio),
  .cfg_valid   (cfg_valid),
  .cfg_ready   (cfg_ready),
  .rsp_valid   (rsp_valid),
  .rsp_code    (rsp_code),
  .resend_req  (resend_req)
);

// File: tb/sim_irq_source_ctrl.sv
`timescale 1ns/1ps
module sim_irq_source_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] src_in = '0;
  logic [7:0] src_mode = 8'hF0;
  logic       rej_valid = 1'b0, eoi_valid = 1'b0, resend_req = 1'b0;
  logic [9:0] rej_num = '0, eoi_num = '0, cfg_num = '0;
  logic       pres_valid, pres_ready = 1'b0;
  logic [9:0] pres_num;
  logic [7:0] pres_server, pres_prio;
  logic       cfg_valid = 1'b0, cfg_ready;
  logic [1:0] cfg_op = '0;
  logic [7:0] cfg_server = '0, cfg_prio = '0;
  logic       rsp_valid;
  logic [7:0] rsp_code, rsp_server, rsp_prio;

  int nchk = 0, nerr = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  irq_source_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .src_mode(src_mode),
    .rej_valid(rej_valid), .rej_num(rej_num), .eoi_valid(eoi_valid), .eoi_num(eoi_num),
    .resend_req(resend_req), .pres_valid(pres_valid), .pres_ready(pres_ready),
    .pres_num(pres_num), .pres_server(pres_server), .pres_prio(pres_prio),
    .cfg_valid(cfg_valid), .cfg_ready(cfg_ready), .cfg_op(cfg_op), .cfg_num(cfg_num),
    .cfg_server(cfg_server), .cfg_prio(cfg_prio), .rsp_valid(rsp_valid),
    .rsp_code(rsp_code), .rsp_server(rsp_server), .rsp_prio(rsp_prio)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cfg(input int op, input int num, input int srv, input int prio,
                     output int code, output int rs, output int rp);
    @(negedge clk);
    while (!cfg_ready) @(negedge clk);
    cfg_valid = 1'b1; cfg_op = 2'(op); cfg_num = 10'(num);
    cfg_server = 8'(srv); cfg_prio = 8'(prio);
    @(negedge clk);
    cfg_valid = 1'b0;
    code = rsp_valid ? int'(rsp_code) : 999;
    rs = int'(rsp_server);
    rp = int'(rsp_prio);
  endtask

  task automatic wait_valid();
    int n = 0;
    @(negedge clk);
    while (!pres_valid && n < 30) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic take();
    pres_ready = 1'b1;
    @(negedge clk);
    pres_ready = 1'b0;
  endtask

  task automatic expect_pres(input string tag, input int num, input int srv, input int prio);
    wait_valid();
    chk({tag, " valid"}, int'(pres_valid), 1);
    chk({tag, " num"}, int'(pres_num), num);
    chk({tag, " server"}, int'(pres_server), srv);
    chk({tag, " prio"}, int'(pres_prio), prio);
    if (pres_valid) take();
  endtask

  task automatic expect_none(input string tag, input int cycles);
    int seen = 0;
    repeat (cycles) begin
      @(negedge clk);
      if (pres_valid) seen++;
    end
    chk({tag, " no presentation"}, seen, 0);
  endtask

  task automatic pulse(input logic [7:0] m);
    @(negedge clk); src_in = src_in | m;
    @(negedge clk); src_in = src_in & ~m;
  endtask

  task automatic reject(input int num);
    @(negedge clk); rej_valid = 1'b1; rej_num = 10'(num);
    @(negedge clk); rej_valid = 1'b0;
  endtask

  task automatic eoi(input int num);
    @(negedge clk); eoi_valid = 1'b1; eoi_num = 10'(num);
    @(negedge clk); eoi_valid = 1'b0;
  endtask

  task automatic resend();
    @(negedge clk); resend_req = 1'b1;
    @(negedge clk); resend_req = 1'b0;
  endtask

  task automatic t_reset();
    int c, s, p;
    chk("R1 pres_valid", int'(pres_valid), 0);
    chk("R1 cfg_ready", int'(cfg_ready), 1);
    cfg(1, 16, 0, 0, c, s, p);
    chk("R1 get16 code", c, 0); chk("R1 get16 server", s, 0); chk("R1 get16 prio", p, 255);
    cfg(1, 23, 0, 0, c, s, p);
    chk("R1 get23 prio", p, 255);
  endtask

  task automatic t_cfg();
    int c, s, p;
    cfg(0, 17, 2, 5, c, s, p); chk("R3 set17 code", c, 0);
    cfg(1, 17, 0, 0, c, s, p);
    chk("R3 get17 server", s, 2); chk("R3 get17 prio", p, 5);
    cfg(0, 15, 1, 1, c, s, p); chk("R2 num below base", c, 253);
    cfg(0, 24, 1, 1, c, s, p); chk("R2 num past end", c, 253);
    cfg(0, 17, 4, 1, c, s, p); chk("R2 server out of range", c, 253);
    cfg(1, 17, 0, 0, c, s, p);
    chk("R2 state kept server", s, 2); chk("R2 state kept prio", p, 5);
  endtask

  task automatic t_msg();
    pulse(8'h02);
    expect_pres("R4 msg", 17, 2, 5);
    expect_none("R4 single shot", 6);
  endtask

  task automatic t_mask();
    int c, s, p;
    pulse(8'h04);
    expect_none("R5 masked msg", 6);
    cfg(0, 18, 1, 3, c, s, p);
    expect_pres("R5 unmask releases", 18, 1, 3);
  endtask

  task automatic t_level();
    int c, s, p;
    cfg(0, 20, 3, 7, c, s, p);
    @(negedge clk); src_in[4] = 1'b1;
    expect_pres("R6 level", 20, 3, 7);
    expect_none("R6 sent blocks", 6);
    eoi(20);
    expect_pres("R6 eoi re-present", 20, 3, 7);
    @(negedge clk); src_in[4] = 1'b0;
    eoi(20);
    expect_none("R6 deasserted", 6);
    eoi(17);
    expect_none("R6 eoi on msg", 6);
  endtask

  task automatic t_reject();
    pulse(8'h02);
    expect_pres("R7 msg first", 17, 2, 5);
    reject(17);
    expect_none("R7 msg held", 6);
    resend();
    expect_pres("R7 msg resend", 17, 2, 5);
    @(negedge clk); src_in[4] = 1'b1;
    expect_pres("R7 level first", 20, 3, 7);
    reject(20);
    expect_none("R7 level held", 6);
    resend();
    expect_pres("R7 level resend", 20, 3, 7);
    @(negedge clk); src_in[4] = 1'b0;
    eoi(20);
    expect_none("R7 quiet", 4);
  endtask

  task automatic t_order();
    int c, s, p;
    cfg(0, 16, 0, 9, c, s, p);
    pulse(8'h03);
    wait_valid();
    chk("R10 lowest first", int'(pres_num), 16);
    repeat (3) @(negedge clk);
    chk("R10 hold valid", int'(pres_valid), 1);
    chk("R10 hold num", int'(pres_num), 16);
    chk("R10 hold prio", int'(pres_prio), 9);
    take();
    expect_pres("R10 second", 17, 2, 5);
  endtask

  task automatic t_scan();
    reject(16);
    reject(17);
    resend();
    chk("R8 cfg locked", int'(cfg_ready), 0);
    wait_valid();
    repeat (3) @(negedge clk);
    chk("R8 paused lock", int'(cfg_ready), 0);
    chk("R8 scan order first", int'(pres_num), 16);
    take();
    expect_pres("R8 scan order second", 17, 2, 5);
    repeat (10) @(negedge clk);
    chk("R8 unlock", int'(cfg_ready), 1);
  endtask

  task automatic t_offon();
    int c, s, p;
    cfg(2, 17, 0, 0, c, s, p); chk("R9 off code", c, 0);
    cfg(1, 17, 0, 0, c, s, p); chk("R9 off prio", p, 255); chk("R9 off server", s, 2);
    pulse(8'h02);
    expect_none("R9 off blocks", 6);
    cfg(3, 17, 0, 0, c, s, p); chk("R9 on code", c, 0);
    expect_pres("R9 on releases", 17, 2, 5);
    cfg(1, 17, 0, 0, c, s, p); chk("R9 on prio", p, 5);
  endtask

  task automatic t_maskq();
    int c, s, p;
    pulse(8'h03);
    wait_valid();
    chk("R11 first held", int'(pres_num), 16);
    cfg(2, 17, 0, 0, c, s, p);
    take();
    expect_none("R11 queued moved", 6);
    cfg(3, 17, 0, 0, c, s, p);
    expect_pres("R11 enable releases", 17, 2, 5);
  endtask

  task automatic t_ignore();
    int c, s, p;
    cfg(0, 21, 1, 4, c, s, p);
    @(negedge clk); src_in[5] = 1'b1;
    expect_pres("R12 level", 21, 1, 4);
    reject(24);
    reject(15);
    eoi(40);
    eoi(5);
    expect_none("R12 bad numbers", 6);
    eoi(21);
    expect_pres("R12 good eoi", 21, 1, 4);
    @(negedge clk); src_in[5] = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cfg();
    t_msg();
    t_mask();
    t_level();
    t_reject();
    t_order();
    t_scan();
    t_offon();
    t_maskq();
    t_ignore();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    #(8 * 100000);
    if (!finished) begin
      finished = 1;
      nchk++;
      nerr++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule